// File: doc/BRIEF.md
# Shared-Address Line Format and Bank Select Register

This block owns one offset of a banked serial-port register map. At that offset sit two registers: a line-format register, whose fields set word length, stop bits, parity and break, and a bank-select register, whose value picks which register bank the rest of the map shows. Bit 7 of the written byte decides which of the two registers a write reaches. Every write updates the bank-select register. The format register is updated only when bit 7 is clear, or when the byte is one of the bank-1 selection codes. A write that moves to any other bank therefore leaves the line format as it was.

A read at the shared offset returns the bank-select byte. The format byte is visible as a read-only shadow at a second offset, and only while bank 3 is selected. The current bank is held by a small state machine with three states. `ST_B0` is bank 0, `ST_B1` is bank 1, and `ST_HI` covers banks 2 and up, with an index register that says which one. Each write to the shared offset takes one of four named transitions:
- `T_FMT`: bit 7 clear, go to `ST_B0`.
- `T_B1`: a bank-1 code, go to `ST_B1`.
- `T_HI`: a high-bank code, go to `ST_HI` and load the index.
- `T_FALL`: any other value with bit 7 set, go to `ST_B0`.

With no write at the shared offset, the state is held. The other offsets of the map are decoded elsewhere.

Top module: `fmt_bank_reg`

## Requirements
- R1: After reset the current bank is 0, every format field is 0, and a read at the shared offset returns 8'h00.
- R2: A read at the shared offset returns the last byte written there, whatever bank is selected.
- R3: A write at the shared offset with bit 7 = 0 loads the whole byte into the format register and selects bank 0.
- R4: A write with bit 7 = 1 and bits 6:5 not equal to 2'b11 is a bank-1 code. It selects bank 1 and also loads the format register. This includes 8'h80.
- R5: The bytes 8'hE0, 8'hE4, 8'hE8 and 8'hEC select banks 2, 3, 4 and 5, and leave the format register unchanged.
- R6: Any other byte with bits 7:5 = 3'b111 selects bank 0 and leaves the format register unchanged.
- R7: While bank 3 is selected, a read at the shadow offset (default 1) returns the format byte. In any other bank, that offset reads 8'h00.
- R8: The bank output changes on the clock edge that completes the write and holds without a write. The very next access already sees the new bank.
- R9: The format fields map from the stored byte as follows: word_len = bits 1:0, stop_two = bit 2, par_en = bit 3, par_even = bit 4, par_stick = bit 5, break_on = bit 6.
- R10: Writes to offsets other than the shared one change neither the bank nor the format. Reads at unrelated offsets return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | ADDR_W | Register offset of the access |
| acc_wr | input | 1 | Write strobe, one cycle per write |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for acc_addr (combinational) |
| cur_bank | output | BANK_W | Currently selected bank number |
| word_len | output | 2 | Word-length code |
| stop_two | output | 1 | Extra stop bit |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| par_stick | output | 1 | Stick parity select |
| break_on | output | 1 | Force break on the line |

## Verification
The bench builds the block with its default parameters: a 3-bit offset, shared offset 3, shadow offset 1 and four high banks starting at 8'hE0 in steps of 4. With these values every bank from 0 to 5 can be reached, so each transition of the bank state machine is exercised, including the return from `ST_HI` to `ST_B0` through the fallback. The shadow offset lies apart from the shared offset, so the bench can read it in bank 3 and in other banks. The bench also hits near-miss bytes next to the high-bank codes, such as 8'hE2 and 8'hF0, to probe the edges of the code decode.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    // Bank state machine states
    typedef enum logic [1:0] {
        ST_B0 = 2'd0,
        ST_B1 = 2'd1,
        ST_HI = 2'd2
    } bank_st_e;

    // Classification of a byte written at the shared offset
    typedef enum logic [1:0] {
        WK_FMT  = 2'd0,   // bit 7 clear
        WK_B1   = 2'd1,   // bank-1 code
        WK_HI   = 2'd2,   // high-bank code
        WK_FALL = 2'd3    // any other bit-7 value
    } wkind_e;

    typedef struct packed {
        logic       brk;
        logic       stick;
        logic       even;
        logic       pen;
        logic       stop2;
        logic [1:0] wlen;
    } fmt_t;

    function automatic logic is_b1_code(input logic [7:0] v);
        return v[7] && (v[6:5] != 2'b11);
    endfunction

endpackage

// File: rtl/fbr_wr_steer.sv
module fbr_wr_steer
    import fbr_pkg::*;
#(
    parameter int HI_BASE = 224,
    parameter int HI_STEP = 4,
    parameter int NUM_HI  = 4,
    parameter int IDX_W   = 2
) (
    input  logic             hit_wr,
    input  logic [7:0]       wdata,
    output wkind_e           wkind,
    output logic [IDX_W-1:0] hi_idx,
    output logic             fmt_we,
    output logic             sel_we
);

    logic [NUM_HI-1:0] hi_match;

    for (genvar gi = 0; gi < NUM_HI; gi++) begin : g_hi_code
        localparam logic [7:0] CODE = 8'(HI_BASE + gi * HI_STEP);
        assign hi_match[gi] = (wdata == CODE);
    end

    always_comb begin
        hi_idx = '0;
        for (int i = 0; i < NUM_HI; i++) begin
            if (hi_match[i]) hi_idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (!wdata[7])           wkind = WK_FMT;
        else if (|hi_match)      wkind = WK_HI;
        else if (is_b1_code(wdata)) wkind = WK_B1;
        else                     wkind = WK_FALL;
    end

    assign sel_we = hit_wr;
    assign fmt_we = hit_wr && ((wkind == WK_FMT) || (wkind == WK_B1));

endmodule

// File: rtl/fbr_bank_fsm.sv
module fbr_bank_fsm
    import fbr_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  wkind_e            wkind,
    input  logic [IDX_W-1:0]  hi_idx,
    output logic [BANK_W-1:0] bank
);

    bank_st_e         state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // Transitions: T_FMT, T_B1, T_HI, T_FALL on a shared-offset write
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (sel_we) begin
            unique case (wkind)
                WK_FMT:  state_d = ST_B0;
                WK_B1:   state_d = ST_B1;
                WK_HI: begin
                    state_d = ST_HI;
                    idx_d   = hi_idx;
                end
                WK_FALL: state_d = ST_B0;
                default: state_d = ST_B0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_B0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_B0:   bank = '0;
            ST_B1:   bank = BANK_W'(1);
            ST_HI:   bank = BANK_W'(2) + BANK_W'(idx_q);
            default: bank = '0;
        endcase
    end

endmodule

// File: rtl/fbr_regs.sv
module fbr_regs
    import fbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fmt_we,
    input  logic       sel_we,
    input  logic [7:0] wdata,
    output logic [7:0] fmt_q,
    output logic [7:0] sel_q,
    output fmt_t       fields
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q <= '0;
            sel_q <= '0;
        end else begin
            if (fmt_we) fmt_q <= wdata;
            if (sel_we) sel_q <= wdata;
        end
    end

    assign fields = fmt_t'(fmt_q[6:0]);

endmodule

// File: rtl/fbr_rd_mux.sv
module fbr_rd_mux #(
    parameter int ADDR_W      = 3,
    parameter int BANK_W      = 3,
    parameter int SHARED_OFS  = 3,
    parameter int SHADOW_OFS  = 1,
    parameter int SHADOW_BANK = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    input  logic [7:0]        sel_q,
    input  logic [7:0]        fmt_q,
    output logic [7:0]        rdata
);

    always_comb begin
        if (addr == ADDR_W'(SHARED_OFS))
            rdata = sel_q;
        else if (addr == ADDR_W'(SHADOW_OFS) && bank == BANK_W'(SHADOW_BANK))
            rdata = fmt_q;
        else
            rdata = '0;
    end

endmodule

// File: rtl/fmt_bank_reg.sv
module fmt_bank_reg
    import fbr_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SHARED_OFS  = 3,
    parameter int SHADOW_OFS  = 1,
    parameter int SHADOW_BANK = 3,
    parameter int HI_BASE     = 224,
    parameter int HI_STEP     = 4,
    parameter int NUM_HI      = 4,
    localparam int IDX_W      = (NUM_HI > 1) ? $clog2(NUM_HI) : 1,
    localparam int BANK_W     = $clog2(NUM_HI + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic [BANK_W-1:0] cur_bank,
    output logic [1:0]        word_len,
    output logic              stop_two,
    output logic              par_en,
    output logic              par_even,
    output logic              par_stick,
    output logic              break_on
);

    logic             hit_wr;
    wkind_e           wkind;
    logic [IDX_W-1:0] hi_idx;
    logic             fmt_we;
    logic             sel_we;
    logic [7:0]       fmt_q;
    logic [7:0]       sel_q;
    fmt_t             fields;

    assign hit_wr = acc_wr && (acc_addr == ADDR_W'(SHARED_OFS));

    fbr_wr_steer #(
        .HI_BASE (HI_BASE),
        .HI_STEP (HI_STEP),
        .NUM_HI  (NUM_HI),
        .IDX_W   (IDX_W)
    ) u_steer (
        .hit_wr (hit_wr),
        .wdata  (acc_wdata),
        .wkind  (wkind),
        .hi_idx (hi_idx),
        .fmt_we (fmt_we),
        .sel_we (sel_we)
    );

    fbr_bank_fsm #(
        .IDX_W  (IDX_W),
        .BANK_W (BANK_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_we (sel_we),
        .wkind  (wkind),
        .hi_idx (hi_idx),
        .bank   (cur_bank)
    );

    fbr_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .fmt_we (fmt_we),
        .sel_we (sel_we),
        .wdata  (acc_wdata),
        .fmt_q  (fmt_q),
        .sel_q  (sel_q),
        .fields (fields)
    );

    fbr_rd_mux #(
        .ADDR_W      (ADDR_W),
        .BANK_W      (BANK_W),
        .SHARED_OFS  (SHARED_OFS),
        .SHADOW_OFS  (SHADOW_OFS),
        .SHADOW_BANK (SHADOW_BANK)
    ) u_rd (
        .addr  (acc_addr),
        .bank  (cur_bank),
        .sel_q (sel_q),
        .fmt_q (fmt_q),
        .rdata (acc_rdata)
    );

    assign word_len  = fields.wlen;
    assign stop_two  = fields.stop2;
    assign par_en    = fields.pen;
    assign par_even  = fields.even;
    assign par_stick = fields.stick;
    assign break_on  = fields.brk;

endmodule

// File: rtl/fmt_bank_reg_chk.sv
module fmt_bank_reg_chk #(
    parameter int ADDR_W      = 3,
    parameter int SHARED_OFS  = 3,
    parameter int SHADOW_OFS  = 1,
    parameter int SHADOW_BANK = 3,
    parameter int NUM_HI      = 4,
    parameter int BANK_W      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_wr,
    input logic [7:0]        acc_wdata,
    input logic [7:0]        acc_rdata,
    input logic [BANK_W-1:0] cur_bank,
    input logic [1:0]        word_len,
    input logic              stop_two,
    input logic              par_en,
    input logic              par_even,
    input logic              par_stick,
    input logic              break_on
);

    logic [6:0] f_vec;
    logic       wr_sh;

    assign f_vec = {break_on, par_stick, par_even, par_en, stop_two, word_len};
    assign wr_sh = acc_wr && (acc_addr == ADDR_W'(SHARED_OFS));

    assert_fmt_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sh && !acc_wdata[7]) |=> (f_vec == $past(acc_wdata[6:0])) && (cur_bank == '0));

    assert_b1_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sh && acc_wdata[7] && (acc_wdata[6:5] != 2'b11))
        |=> (cur_bank == BANK_W'(1)) && (f_vec == $past(acc_wdata[6:0])));

    assert_fmt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sh && (acc_wdata[7:5] == 3'b111)) |=> $stable(f_vec));

    assert_bank_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_bank < BANK_W'(NUM_HI + 2));

    assert_rd_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sh |=> ((acc_addr != ADDR_W'(SHARED_OFS)) || (acc_rdata == $past(acc_wdata))));

    assert_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_bank == BANK_W'(SHADOW_BANK)) && (acc_addr == ADDR_W'(SHADOW_OFS)))
        |-> (acc_rdata[6:0] == f_vec));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> $stable(cur_bank));

    assert_other_ofs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && (acc_addr != ADDR_W'(SHARED_OFS))) |=> ($stable(f_vec) && $stable(cur_bank)));

endmodule

bind fmt_bank_reg fmt_bank_reg_chk #(
    .ADDR_W      (ADDR_W),
    .SHARED_OFS  (SHARED_OFS),
    .SHADOW_OFS  (SHADOW_OFS),
    .SHADOW_BANK (SHADOW_BANK),
    .NUM_HI      (NUM_HI),
    .BANK_W      (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_addr  (acc_addr),
    .acc_wr    (acc_wr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .cur_bank  (cur_bank),
    .word_len  (word_len),
    .stop_two  (stop_two),
    .par_en    (par_en),
    .par_even  (par_even),
    .par_stick (par_stick),
    .break_on  (break_on)
);

// File: tb/fmt_bank_reg_bench.sv
module fmt_bank_reg_bench;

    localparam int ADDR_W = 3;
    localparam int BANK_W = 3;
    localparam logic [2:0] SH  = 3'd3;
    localparam logic [2:0] SHD = 3'd1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b1;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              acc_wr = 1'b0;
    logic [7:0]        acc_wdata = '0;
    logic [7:0]        acc_rdata;
    logic [BANK_W-1:0] cur_bank;
    logic [1:0]        word_len;
    logic              stop_two, par_en, par_even, par_stick, break_on;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_fmt = 8'h00;

    always #2.5 clk = ~clk;

    fmt_bank_reg u_fmt_bank_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_addr  (acc_addr),
        .acc_wr    (acc_wr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .cur_bank  (cur_bank),
        .word_len  (word_len),
        .stop_two  (stop_two),
        .par_en    (par_en),
        .par_even  (par_even),
        .par_stick (par_stick),
        .break_on  (break_on)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_addr  = a;
        acc_wdata = d;
        acc_wr    = 1'b1;
        @(negedge clk);
        acc_wr    = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, output logic [7:0] d);
        acc_addr = a;
        #1;
        d = acc_rdata;
    endtask

    function automatic logic [6:0] fvec();
        return {break_on, par_stick, par_even, par_en, stop_two, word_len};
    endfunction

    task automatic t_reset();
        logic [7:0] r;
        chk("R1 bank", int'(cur_bank), 0);
        chk("R1 fields", int'(fvec()), 0);
        do_read(SH, r);
        chk("R1 shared read", int'(r), 0);
    endtask

    task automatic t_fmt_write();
        logic [7:0] r;
        do_write(SH, 8'h3A);
        exp_fmt = 8'h3A;
        chk("R3 bank", int'(cur_bank), 0);
        chk("R3 fields", int'(fvec()), 'h3A);
        do_read(SH, r);
        chk("R2 shared read", int'(r), 'h3A);
    endtask

    task automatic t_fields();
        do_write(SH, 8'h5B);
        exp_fmt = 8'h5B;
        chk("R9 word_len", int'(word_len), 3);
        chk("R9 stop_two", int'(stop_two), 0);
        chk("R9 par_en", int'(par_en), 1);
        chk("R9 par_even", int'(par_even), 1);
        chk("R9 par_stick", int'(par_stick), 0);
        chk("R9 break_on", int'(break_on), 1);
        do_write(SH, 8'h24);
        exp_fmt = 8'h24;
        chk("R9 stop_two set", int'(stop_two), 1);
        chk("R9 par_stick set", int'(par_stick), 1);
    endtask

    task automatic t_bank1();
        logic [7:0] r;
        do_write(SH, 8'h80);
        exp_fmt = 8'h80;
        chk("R4 bank 80", int'(cur_bank), 1);
        chk("R4 fields 80", int'(fvec()), 0);
        do_write(SH, 8'hC7);
        exp_fmt = 8'hC7;
        chk("R4 bank C7", int'(cur_bank), 1);
        chk("R4 fields C7", int'(fvec()), 'h47);
        do_read(SH, r);
        chk("R2 shared read bank1", int'(r), 'hC7);
    endtask

    task automatic t_high_banks();
        logic [7:0] r;
        for (int i = 0; i < 4; i++) begin
            do_write(SH, 8'(8'hE0 + 4 * i));
            chk("R5 bank", int'(cur_bank), 2 + i);
            chk("R5 fmt unchanged", int'(fvec()), int'(exp_fmt[6:0]));
            do_read(SH, r);
            chk("R2 shared read hi", int'(r), 'hE0 + 4 * i);
        end
    endtask

    task automatic t_fallback();
        do_write(SH, 8'hE4);
        do_write(SH, 8'hF0);
        chk("R6 bank F0", int'(cur_bank), 0);
        chk("R6 fmt F0", int'(fvec()), int'(exp_fmt[6:0]));
        do_write(SH, 8'hE8);
        do_write(SH, 8'hE2);
        chk("R6 bank E2", int'(cur_bank), 0);
        chk("R6 fmt E2", int'(fvec()), int'(exp_fmt[6:0]));
    endtask

    task automatic t_shadow_timing();
        logic [7:0] r;
        do_write(SH, 8'h15);
        exp_fmt = 8'h15;
        @(negedge clk);
        acc_addr  = SH;
        acc_wdata = 8'hE4;
        acc_wr    = 1'b1;
        #1;
        chk("R8 bank before edge", int'(cur_bank), 0);
        @(negedge clk);
        acc_wr = 1'b0;
        chk("R8 bank after edge", int'(cur_bank), 3);
        do_read(SHD, r);
        chk("R7 shadow bank3", int'(r), 'h15);
        @(negedge clk);
        chk("R8 bank holds", int'(cur_bank), 3);
        do_write(SH, 8'hEC);
        do_read(SHD, r);
        chk("R7 shadow bank5", int'(r), 0);
        do_write(SH, 8'h00);
        exp_fmt = 8'h00;
        do_read(SHD, r);
        chk("R7 shadow bank0", int'(r), 0);
    endtask

    task automatic t_other_offsets();
        logic [7:0] r;
        do_write(SH, 8'h2D);
        exp_fmt = 8'h2D;
        do_write(3'd0, 8'h00);
        do_write(3'd2, 8'hE4);
        do_write(3'd7, 8'h7F);
        chk("R10 bank", int'(cur_bank), 0);
        chk("R10 fmt", int'(fvec()), 'h2D);
        do_read(3'd5, r);
        chk("R10 read other", int'(r), 0);
        do_read(SH, r);
        chk("R10 shared intact", int'(r), 'h2D);
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fmt_write();
        t_fields();
        t_bank1();
        t_high_banks();
        t_fallback();
        t_shadow_timing();
        t_other_offsets();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule